// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned N-bit numbers by examining one multiplier bit per pair of clock cycles. A multiplicand register, a multiplier register that fills up with the low product half, an accumulator holding the high half, a carry bit and a down counter form the datapath. A three-state sequencer drives it: a waiting state, an add step and a shift step.

The caller loads both operands with a load strobe while the block is idle, then pulses start. The block raises busy, alternates between the add step and the shift step N times, and returns to idle with a one-cycle done pulse. The 2N-bit product is then readable on the product output until the next load or start. The load strobe and start may be given in the same cycle; the operands captured at that edge are the ones multiplied.

Top module: `shift_add_mul`

## Requirements
- R1: A synchronous active-high reset makes busy 0, done 0 and product 0 at the next edge.
- R2: While idle, ld_en captures mcand_in as the multiplicand and mplier_in into the low half of product (product[N-1:0]). While busy, ld_en has no effect.
- R3: start while idle clears the high product half (product[2N-1:N]) and busy is 1 from the next edge on.
- R4: While idle with start and ld_en both low, product keeps its value.
- R5: In the add step the accumulator gains the multiplicand, with carry-out kept, only when the current multiplier bit product[0] is 1; when it is 0, product is unchanged.
- R6: In the shift step carry, accumulator and low half shift right together by one place, so product[N-2:0] takes the previous product[N-1:1], and the carry is cleared.
- R7: A run lasts exactly 2N cycles: busy is 1 for 2N consecutive cycles after the edge that accepts start. The counter, loaded with N-1, is tested before its decrement in the shift step.
- R8: done is 1 for exactly one cycle, in the first idle cycle after a run, and never while busy.
- R9: After a run, product equals the multiplicand times the multiplier value held when the run began, for all operand pairs including zero and all-ones operands.
- R10: start while busy has no effect on the run in progress.
- R11: With ld_en and start high in the same idle cycle, the newly loaded operands are the ones multiplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Operand load strobe, honoured only when idle |
| mcand_in | input | N | Multiplicand value to load |
| mplier_in | input | N | Multiplier value to load |
| start | input | 1 | Begin a multiplication, honoured only when idle |
| product | output | 2N | Accumulator (high half) concatenated with multiplier/low-product register |
| busy | output | 1 | High while a multiplication is running |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
Checked on every cycle by properties: product is held while idle and no command arrives, the high half is cleared when a run starts, the add step leaves everything untouched when the current multiplier bit is 0, each shift step moves the low bits down by one, the counter steps down by one between shift steps, the multiplicand never changes during a run, and done is a single-cycle pulse outside busy. Only the bench scenarios can show that the final product is the true arithmetic result for corner and random operand pairs, that the run length is exactly 2N cycles, and that loads or starts given while busy leave the result and its timing unchanged.

// File: rtl/mul_pkg.sv
package mul_pkg;
  // Sequencer states: wait, conditional add, shift with count-down
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADD   = 2'd1,
    S_SHIFT = 2'd2
  } mstate_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ld_en,
  input  logic          q0,
  output mstate_e       st,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          done,
  output logic          do_init,
  output logic          do_load,
  output logic          do_add,
  output logic          do_shift
);
  localparam logic [CW-1:0] CNT_INIT = CW'(N - 1);

  logic cnt_zero;

  always_comb begin
    cnt_zero = (cnt == '0);
    do_init  = (st == S_IDLE) && start;
    do_load  = (st == S_IDLE) && ld_en;
    do_add   = (st == S_ADD) && q0;
    do_shift = (st == S_SHIFT);
    busy     = (st != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            st  <= S_ADD;
            cnt <= CNT_INIT;
          end
        end
        S_ADD: st <= S_SHIFT;
        S_SHIFT: begin
          cnt <= cnt - 1'b1;
          // zero test uses the count before this cycle's decrement
          if (cnt_zero) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_ADD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           do_init,
  input  logic           do_load,
  input  logic           do_add,
  input  logic           do_shift,
  input  logic [N-1:0]   mcand_in,
  input  logic [N-1:0]   mplier_in,
  output logic           q0,
  output logic [N-1:0]   b_out,
  output logic [2*N-1:0] product
);
  logic [N-1:0] acc_r;
  logic [N-1:0] lo_r;
  logic [N-1:0] mcand_r;
  logic         cy_r;
  logic [N:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_r} + {1'b0, mcand_r};
    q0      = lo_r[0];
    b_out   = mcand_r;
    product = {acc_r, lo_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r   <= '0;
      lo_r    <= '0;
      mcand_r <= '0;
      cy_r    <= 1'b0;
    end else begin
      if (do_load) begin
        mcand_r <= mcand_in;
        lo_r    <= mplier_in;
      end
      if (do_init) begin
        acc_r <= '0;
        cy_r  <= 1'b0;
      end
      if (do_add) begin
        {cy_r, acc_r} <= sum;
      end
      if (do_shift) begin
        acc_r <= {cy_r, acc_r[N-1:1]};
        lo_r  <= {acc_r[0], lo_r[N-1:1]};
        cy_r  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic [N-1:0]   mcand_in,
  input  logic [N-1:0]   mplier_in,
  input  logic           start,
  output logic [2*N-1:0] product,
  output logic           busy,
  output logic           done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  mul_pkg::mstate_e st;
  logic [CW-1:0]    cnt;
  logic [N-1:0]     b_reg;
  logic             q0, do_init, do_load, do_add, do_shift;

  mul_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ld_en(ld_en), .q0(q0),
    .st(st), .cnt(cnt), .busy(busy), .done(done),
    .do_init(do_init), .do_load(do_load), .do_add(do_add), .do_shift(do_shift)
  );

  mul_datapath #(.N(N)) u_dp (
    .clk(clk), .rst(rst),
    .do_init(do_init), .do_load(do_load), .do_add(do_add), .do_shift(do_shift),
    .mcand_in(mcand_in), .mplier_in(mplier_in),
    .q0(q0), .b_out(b_reg), .product(product)
  );
endmodule

// File: rtl/mul_checker.sv
module mul_checker
  import mul_pkg::*;
#(
  parameter int N = 8,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           ld_en,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product,
  input mstate_e        st,
  input logic [CW-1:0]  cnt,
  input logic [N-1:0]   b_reg
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !ld_en) |=> $stable(product));

  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && product[2*N-1:N] == '0));

  a_r5_skip_add: assert property (@(posedge clk) disable iff (rst)
    (st == S_ADD && !product[0]) |=> $stable(product));

  a_r6_shift_low: assert property (@(posedge clk) disable iff (rst)
    (st == S_SHIFT) |=> (product[N-2:0] == $past(product[N-1:1])));

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_SHIFT && cnt != '0) |=> (st == S_ADD && cnt == $past(cnt) - 1'b1));

  a_r2_operand_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(b_reg));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind shift_add_mul mul_checker #(.N(N)) u_mul_checker (
  .clk(clk), .rst(rst), .start(start), .ld_en(ld_en), .busy(busy),
  .done(done), .product(product), .st(st), .cnt(cnt), .b_reg(b_reg)
);

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_en = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand_in = '0;
  logic [N-1:0]   mplier_in = '0;
  logic [2*N-1:0] product;
  logic           busy, done;

  int checks = 0;
  int failures = 0;
  string cur_req = "R9";

  shift_add_mul #(.N(N)) i_shift_add_mul (
    .clk(clk), .rst(rst), .ld_en(ld_en), .mcand_in(mcand_in),
    .mplier_in(mplier_in), .start(start), .product(product),
    .busy(busy), .done(done)
  );

  always #2 clk = ~clk;  // 250 MHz

  // behavioural reference: operand values, run countdown, expected result
  logic [N-1:0]   m_b = '0, m_lo = '0, m_hi = '0;
  logic [2*N-1:0] m_res = '0;
  logic           m_busy = 1'b0, m_done = 1'b0;
  int             m_left = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_b = '0; m_lo = '0; m_hi = '0; m_busy = 1'b0; m_done = 1'b0; m_left = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          {m_hi, m_lo} = m_res;
        end
      end else begin
        if (ld_en) begin
          m_b  = mcand_in;
          m_lo = mplier_in;
        end
        if (start) begin
          m_hi   = '0;
          m_res  = (2*N)'(m_b) * (2*N)'(m_lo);
          m_busy = 1'b1;
          m_left = 2*N;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [2*N-1:0] act,
                     input logic [2*N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R7 busy", busy, m_busy);
      chk(done == m_done, "R8 done", done, m_done);
      if (!m_busy)
        chk(product == {m_hi, m_lo}, cur_req, product, {m_hi, m_lo});
    end
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ops(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    ld_en = 1'b1; mcand_in = a; mplier_in = b;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    load_ops(a, b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R3: busy already high one edge after start
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    idle_cycles(2*N + 1);
  endtask

  task automatic run_all;
    idle_cycles(3);
    // R1: reset state
    chk(product == '0 && !busy && !done, "R1 reset", product, 0);
    rst = 1'b0;
    idle_cycles(2);

    cur_req = "R9"; run_mul(8'd5, 8'd3);
    cur_req = "R9"; run_mul(8'd0, 8'd200);
    cur_req = "R9"; run_mul(8'd173, 8'd0);
    cur_req = "R9"; run_mul(8'hFF, 8'hFF);
    cur_req = "R5"; run_mul(8'd1, 8'h80);
    cur_req = "R6"; run_mul(8'h80, 8'h01);

    // R4: idle, no command, product must hold
    cur_req = "R4"; idle_cycles(6);

    // R2: load while idle changes the low half
    cur_req = "R2"; load_ops(8'd9, 8'd77); idle_cycles(2);

    // R10 and R2: start and load while busy are ignored
    cur_req = "R10";
    @(negedge clk); ld_en = 1'b1; mcand_in = 8'd11; mplier_in = 8'd13; start = 1'b1;
    @(negedge clk); ld_en = 1'b0; start = 1'b0;
    idle_cycles(3);
    @(negedge clk); start = 1'b1; ld_en = 1'b1; mcand_in = 8'd250; mplier_in = 8'd250;
    @(negedge clk); start = 1'b0; ld_en = 1'b0;
    idle_cycles(2*N);
    chk(product == 16'd143, "R10 R2 ignored while busy", product, 16'd143);

    // R11: load and start together
    cur_req = "R11";
    @(negedge clk); ld_en = 1'b1; start = 1'b1; mcand_in = 8'd200; mplier_in = 8'd3;
    @(negedge clk); ld_en = 1'b0; start = 1'b0;
    idle_cycles(2*N + 1);
    chk(product == 16'd600, "R11 combined load start", product, 16'd600);

    // restart without reload: multiplier is the previous low half
    cur_req = "R9";
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    idle_cycles(2*N + 1);

    for (int i = 0; i < 30; i++) begin
      cur_req = "R9";
      run_mul(N'($urandom), N'($urandom));
    end

    // R1: reset mid-run
    @(negedge clk); ld_en = 1'b1; mcand_in = 8'd7; mplier_in = 8'd7;
    @(negedge clk); ld_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0; idle_cycles(3);
    rst = 1'b1; idle_cycles(2);
    chk(product == '0 && !busy && !done, "R1 reset mid-run", product, 0);
    rst = 1'b0; idle_cycles(2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule